// File: doc/BRIEF.md
# Serial Memory Read Front-End (SPI Mode 0 Slave)

This block is the command side of a small serial memory. It runs on the system clock and brings the serial clock, the active-low select and the serial data input into that domain through synchronisers. It assembles an 8-bit command from the serial input and decodes it. The array read command then takes a 16-bit byte address and streams bytes from a synchronous memory port, most significant bit first, for as long as the device stays selected. Another command returns the status byte. Two more commands set and clear the write-enable latch.

Each byte of a read is fetched from the memory port one byte ahead of its use, so the serial output never waits for the array. The read address counts up without end and wraps from the top location to zero. While the outer write engine reports an internal write cycle, the block accepts only the status read. Every other command is dropped and the block stays silent until the device is deselected. When that write cycle ends, the write-enable latch clears.

Top module: `spi_rd_front`

## Requirements
- R1: After reset, `so_oe`, `wel` and `mem_rd_en` are all 0.
- R2: Command 0x03 followed by a 16-bit address, MSB first, returns the byte at that address on `so`, MSB first. `so` changes only after a falling edge of `sck` and is valid at the next rising edge.
- R3: While `cs_n` stays low after a read command, each further byte comes from the next address up.
- R4: A read that passes the highest array location (0x7FFF with the default `ARRAY_AW` = 15) continues at address 0.
- R5: Address bits at and above `ARRAY_AW` are ignored. With the default, 0x8000|a returns the same data as a.
- R6: Command 0x05 returns a status byte with bit 0 = `wr_busy`, bit 1 = write-enable latch and bits 7..2 = 0. The byte repeats for as long as `cs_n` stays low.
- R7: Command 0x06 sets `wel` and command 0x04 clears it.
- R8: While `wr_busy` is 1, every command other than 0x05 is ignored: `so_oe` stays 0 and `wel` does not change.
- R9: A falling edge of `wr_busy` clears `wel`.
- R10: `so_oe` is 0 during the command and address bytes and after `cs_n` rises. Raising `cs_n` part-way through a byte discards that byte, and the next selection decodes a new command.
- R11: Commands 0x02, 0x01 and any unassigned code drive nothing on `so` and leave `wel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, asynchronous to `clk` |
| cs_n | input | 1 | Active-low device select, asynchronous |
| si | input | 1 | Serial data in, sampled on the rising edge of `sck` |
| so | output | 1 | Serial data out, updated after the falling edge of `sck` |
| so_oe | output | 1 | Output enable for `so` (0 = high impedance) |
| wr_busy | input | 1 | Internal write cycle in progress, from the write engine |
| wel | output | 1 | Write-enable latch |
| mem_rd_en | output | 1 | One-cycle read strobe to the array |
| mem_addr | output | ARRAY_AW | Array byte address |
| mem_rdata | input | 8 | Array data, valid one cycle after `mem_rd_en` |

## Verification
The bench streams reads across the top of the array and checks that they continue at zero. A counter that saturated, or one that carried into the high address bits, would return the wrong bytes. It sets address bit 15 on some reads. A block that used that bit would ask the memory for a different location. It keeps `wr_busy` high while sending reads and write-enable commands. A block that decoded them would drive `so` or change `wel`. It also raises `cs_n` in the middle of a byte. A design that did not clear its bit count at deselect would misframe the next command.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    localparam int CMD_W  = 8;
    localparam int ADDR_W = 16;

    localparam logic [CMD_W-1:0] OP_WRSR = 8'h01;
    localparam logic [CMD_W-1:0] OP_WRIT = 8'h02;
    localparam logic [CMD_W-1:0] OP_READ = 8'h03;
    localparam logic [CMD_W-1:0] OP_WRDI = 8'h04;
    localparam logic [CMD_W-1:0] OP_RDSR = 8'h05;
    localparam logic [CMD_W-1:0] OP_WREN = 8'h06;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADR,
        PH_RD,
        PH_STS,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        phase_e             ph;
        logic [3:0]         cnt;
        logic [ADDR_W-1:0]  sh;
        logic [ADDR_W-1:0]  addr;
        logic [7:0]         tx;
        logic [7:0]         nxt;
        logic [2:0]         ocnt;
        logic               so;
        logic               oe;
        logic               fetch;
        logic               pend;
    } core_t;

endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    always_comb begin
        for (int s = 0; s < STAGES; s++) begin
            chain_d[s] = (s == 0) ? din : chain_q[(s == 0) ? 0 : s - 1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RST_VAL;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_rd_edge.sv
module spi_rd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
        fall   = ~lvl & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/spi_rd_wel.sv
module spi_rd_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic set_req,
    input  logic clr_req,
    output logic wel
);
    logic wel_d, wel_q, busy_d, busy_q;

    always_comb begin
        busy_d = busy;
        wel_d  = wel_q;
        if (busy_q && !busy)  wel_d = 1'b0;
        else if (clr_req)     wel_d = 1'b0;
        else if (set_req)     wel_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            wel_q  <= wel_d;
            busy_q <= busy_d;
        end
    end

    assign wel = wel_q;
endmodule

// File: rtl/spi_rd_core.sv
module spi_rd_core
    import spi_rd_pkg::*;
#(
    parameter int ARRAY_AW = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                rise,
    input  logic                fall,
    input  logic                si_s,
    input  logic                busy,
    input  logic                wel,
    input  logic [7:0]          mem_rdata,
    output logic                mem_rd_en,
    output logic [ARRAY_AW-1:0] mem_addr,
    output logic                so,
    output logic                so_oe,
    output logic                wren_req,
    output logic                wrdi_req,
    output logic                in_hdr
);
    localparam logic [ADDR_W:0]   AM_WIDE = (ADDR_W + 1)'((ADDR_W + 1)'(1) << ARRAY_AW) - 1'b1;
    localparam logic [ADDR_W-1:0] AMASK   = AM_WIDE[ADDR_W-1:0];

    core_t q, d;
    logic [7:0] status;
    logic [7:0] op;
    logic [ADDR_W-1:0] adr_in;

    always_comb begin
        d        = q;
        d.fetch  = 1'b0;
        d.pend   = q.fetch;
        wren_req = 1'b0;
        wrdi_req = 1'b0;
        status   = {6'b0, wel, busy};
        op       = {q.sh[6:0], si_s};
        adr_in   = {q.sh[ADDR_W-2:0], si_s};

        if (q.pend && q.ph == PH_RD) begin
            d.nxt  = mem_rdata;
            d.addr = (q.addr + 1'b1) & AMASK;
        end

        if (!sel) begin
            d.ph   = PH_OPC;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.ocnt = '0;
        end else begin
            if (rise) begin
                unique case (q.ph)
                    PH_OPC: begin
                        d.sh  = {q.sh[ADDR_W-2:0], si_s};
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == 4'd7) begin
                            d.cnt = '0;
                            d.ph  = PH_SKIP;
                            if (!busy || op == OP_RDSR) begin
                                unique case (op)
                                    OP_READ: d.ph = PH_ADR;
                                    OP_RDSR: begin
                                        d.ph  = PH_STS;
                                        d.nxt = status;
                                    end
                                    OP_WREN: wren_req = 1'b1;
                                    OP_WRDI: wrdi_req = 1'b1;
                                    default: d.ph = PH_SKIP;
                                endcase
                            end
                        end
                    end
                    PH_ADR: begin
                        d.sh  = adr_in;
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == 4'd15) begin
                            d.addr  = adr_in & AMASK;
                            d.fetch = 1'b1;
                            d.ph    = PH_RD;
                            d.ocnt  = '0;
                        end
                    end
                    default: d.cnt = q.cnt;
                endcase
            end

            if (fall && (q.ph == PH_RD || q.ph == PH_STS)) begin
                d.oe   = 1'b1;
                d.ocnt = q.ocnt + 1'b1;
                if (q.ocnt == 3'd0) begin
                    d.so = q.nxt[7];
                    d.tx = {q.nxt[6:0], 1'b0};
                    if (q.ph == PH_RD) d.fetch = 1'b1;
                    else               d.nxt   = status;
                end else begin
                    d.so = q.tx[7];
                    d.tx = {q.tx[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= PH_OPC;
        end else begin
            q <= d;
        end
    end

    assign mem_rd_en = q.fetch;
    assign mem_addr  = q.addr[ARRAY_AW-1:0];
    assign so        = q.so;
    assign so_oe     = q.oe;
    assign in_hdr    = (q.ph == PH_OPC) || (q.ph == PH_ADR);
endmodule

// File: rtl/spi_rd_front.sv
module spi_rd_front #(
    parameter int ARRAY_AW    = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck,
    input  logic                cs_n,
    input  logic                si,
    output logic                so,
    output logic                so_oe,
    input  logic                wr_busy,
    output logic                wel,
    output logic                mem_rd_en,
    output logic [ARRAY_AW-1:0] mem_addr,
    input  logic [7:0]          mem_rdata
);
    logic [2:0] pins_s;
    logic       sck_s, cs_n_s, si_s;
    logic       sck_rise, sck_fall;
    logic       wren_req, wrdi_req;
    logic       in_hdr;

    spi_rd_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sck, cs_n, si}),
        .dout (pins_s)
    );

    assign sck_s  = pins_s[2];
    assign cs_n_s = pins_s[1];
    assign si_s   = pins_s[0];

    spi_rd_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sck_s),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    spi_rd_core #(
        .ARRAY_AW(ARRAY_AW)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (~cs_n_s),
        .rise     (sck_rise),
        .fall     (sck_fall),
        .si_s     (si_s),
        .busy     (wr_busy),
        .wel      (wel),
        .mem_rdata(mem_rdata),
        .mem_rd_en(mem_rd_en),
        .mem_addr (mem_addr),
        .so       (so),
        .so_oe    (so_oe),
        .wren_req (wren_req),
        .wrdi_req (wrdi_req),
        .in_hdr   (in_hdr)
    );

    spi_rd_wel u_wel (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (wr_busy),
        .set_req(wren_req),
        .clr_req(wrdi_req),
        .wel    (wel)
    );
endmodule

// File: rtl/spi_rd_front_chk.sv
module spi_rd_front_chk (
    input logic clk,
    input logic rst_n,
    input logic sck_s,
    input logic cs_n_s,
    input logic in_hdr,
    input logic so,
    input logic so_oe,
    input logic wr_busy,
    input logic wel,
    input logic mem_rd_en
);
    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_s) |=> !so_oe); // R10
    AST_HEADER_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        in_hdr |-> !so_oe); // R10
    AST_SO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sck_s |=> $stable(so)); // R2
    AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en); // R3
    AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_busy) |=> !wel); // R9
    AST_BUSY_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && !wel) |=> !wel); // R8
endmodule

bind spi_rd_front spi_rd_front_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (sck_s),
    .cs_n_s   (cs_n_s),
    .in_hdr   (in_hdr),
    .so       (so),
    .so_oe    (so_oe),
    .wr_busy  (wr_busy),
    .wel      (wel),
    .mem_rd_en(mem_rd_en)
);

// File: tb/spi_rd_front_tb.sv
`timescale 1ns/1ps
module spi_rd_front_tb;
    localparam int AW = 15;
    localparam int H  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic          so, so_oe, wel, mem_rd_en;
    logic          wr_busy = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata = 8'h00;
    int            nchk = 0, nerr = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    spi_rd_front u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .wr_busy(wr_busy), .wel(wel),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mval(input logic [AW-1:0] a);
        return a[7:0] ^ {a[14:8], 1'b0} ^ 8'hA5;
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rdata <= mval(mem_addr);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
        rx = '0;
        oe_any = 1'b0;
        for (int i = 0; i < 8; i++) begin
            si = tx[7-i];
            repeat (H) @(negedge clk);
            rx = {rx[6:0], so};
            oe_any = oe_any | so_oe;
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic sel_on();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic sel_off();
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (3*H) @(negedge clk);
    endtask

    task automatic do_read(input logic [15:0] a, input int n, input string req);
        logic [7:0] rx;
        logic oe;
        logic [AW-1:0] exp_a;
        sel_on();
        xfer(8'h03, rx, oe);   check("R10 oe in opcode", oe, 0);
        xfer(a[15:8], rx, oe); check("R10 oe in addr hi", oe, 0);
        xfer(a[7:0], rx, oe);  check("R10 oe in addr lo", oe, 0);
        exp_a = a[AW-1:0];
        for (int k = 0; k < n; k++) begin
            xfer(8'($urandom), rx, oe);
            check({req, " read oe"}, oe, 1);
            check({req, " read data"}, rx, mval(exp_a));
            exp_a = exp_a + 1'b1;
        end
        sel_off();
        check("R10 oe after deselect", so_oe, 0);
    endtask

    task automatic do_status(input int n, input logic [7:0] exp, input string req);
        logic [7:0] rx;
        logic oe;
        sel_on();
        xfer(8'h05, rx, oe);
        check("R10 oe in status opcode", oe, 0);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, rx, oe);
            check({req, " status oe"}, oe, 1);
            check({req, " status byte"}, rx, exp);
        end
        sel_off();
    endtask

    task automatic do_cmd(input logic [7:0] op, input int extra, output logic oe_any);
        logic [7:0] rx;
        logic oe;
        sel_on();
        xfer(op, rx, oe);
        oe_any = oe;
        for (int k = 0; k < extra; k++) begin
            xfer(8'($urandom), rx, oe);
            oe_any = oe_any | oe;
        end
        sel_off();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic oe;
        logic [7:0] rx;
        process::self().srandom(32'h5EED_0042);
        repeat (5) @(negedge clk);
        check("R1 so_oe reset", so_oe, 0);
        check("R1 wel reset", wel, 0);
        check("R1 mem_rd_en reset", mem_rd_en, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 so_oe after reset", so_oe, 0);

        do_read(16'h0123, 1, "R2");
        do_read(16'h1000, 5, "R3");
        do_read(16'h7FFD, 5, "R4");
        do_read(16'h8042, 3, "R5");
        do_read(16'hFFFF, 2, "R5 R4");

        do_status(3, 8'h00, "R6");
        do_cmd(8'h06, 0, oe);
        check("R7 wren no oe", oe, 0);
        check("R7 wel set", wel, 1);
        do_status(2, 8'h02, "R6 R7");
        do_cmd(8'h04, 0, oe);
        check("R7 wel clear", wel, 0);

        do_cmd(8'h02, 4, oe); check("R11 write ignored oe", oe, 0);
        check("R11 write wel", wel, 0);
        do_cmd(8'h01, 2, oe); check("R11 wrsr ignored oe", oe, 0);
        do_cmd(8'hFF, 2, oe); check("R11 unknown ignored oe", oe, 0);
        do_cmd(8'h06, 0, oe);
        do_cmd(8'hA7, 2, oe); check("R11 unknown keeps wel", wel, 1);

        @(negedge clk); wr_busy = 1'b1;
        do_status(2, 8'h03, "R6 busy");
        do_cmd(8'h03, 4, oe); check("R8 read ignored when busy", oe, 0);
        do_cmd(8'h04, 0, oe); check("R8 wrdi ignored when busy", wel, 1);
        @(negedge clk); wr_busy = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 wel cleared by busy end", wel, 0);
        @(negedge clk); wr_busy = 1'b1;
        do_cmd(8'h06, 0, oe); check("R8 wren ignored when busy", wel, 0);
        do_status(1, 8'h01, "R6 R8 busy");
        @(negedge clk); wr_busy = 1'b0;
        repeat (3) @(negedge clk);

        sel_on();
        for (int i = 0; i < 4; i++) begin
            si = 1'b1;
            repeat (H) @(negedge clk); sck = 1'b1;
            repeat (H) @(negedge clk); sck = 1'b0;
        end
        sel_off();
        check("R10 abort no oe", so_oe, 0);
        do_status(1, 8'h00, "R10 fresh decode");

        for (int t = 0; t < 20; t++) begin
            do_read(16'($urandom), 1 + int'($urandom_range(0, 5)), "R3 random");
        end
        do_read(16'h7FFF, 2, "R4 top");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule